// File: doc/BRIEF.md
# Byte-Parallel Self-Synchronizing Scrambler

This block whitens a byte stream with the self-synchronizing polynomial 1 + x^-4 + x^-7. It accepts one byte per clock. The eight serial bit steps are unrolled into one combinational chain, so a whole byte passes through the scrambler in a single cycle. A 7-bit history register holds the last seven bits shifted through the chain and changes only when a byte is accepted.

A parameter selects the mode. In scramble mode each produced bit is fed back into the history. In descramble mode the received bit is fed back instead, which makes the descrambler the exact inverse of the scrambler. The descrambler also locks onto any scrambled stream within seven bits, whatever history it starts from.

The history resets to a nonzero seed. Software can overwrite it at run time through a seed-load strobe. The output byte is registered, so a result appears one cycle after its input byte.

Top module: `byte_scrambler`

## Requirements
- R1: In scramble mode every output bit equals the input bit XOR the scrambled bit produced 4 bit-steps earlier XOR the one produced 7 bit-steps earlier.
- R2: One byte is accepted on every cycle that in_valid is high. out_valid is high exactly in the cycle after such a cycle, and out_data then carries that byte's result.
- R3: Bit 0 of in_data is processed first and bit 7 last. With the history all ones, input 0x00 yields 0x70.
- R4: While rst_n is low, out_valid is 0 and out_data is 0x00, and the history is loaded with SEED (default all ones). After a reset the first byte 0x00 again yields 0x70.
- R5: In a cycle with in_valid low and seed_load low, the history does not change. In a cycle after in_valid was low, out_data keeps its previous value.
- R6: When seed_load is high, the history takes seed_value. If in_valid is also high in that cycle, that byte is processed starting from seed_value, and its result then advances the history.
- R7: With MODE set to descramble, the received bit is fed back into the history. A descrambler fed with a scrambler's output returns the original bytes.
- R8: A descrambler whose history disagrees with the scrambler produces correct bytes from the second byte it receives onward.
- R9: After an accepted byte, history bit k holds bit 7-k of the bits that were fed back: the output byte in scramble mode, the input byte in descramble mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is present this cycle |
| in_data | input | 8 | Input byte, bit 0 processed first |
| seed_load | input | 1 | Overwrite the history with seed_value |
| seed_value | input | 7 | Value loaded into the history |
| out_valid | output | 1 | out_data holds a new result |
| out_data | output | 8 | Registered scrambled or descrambled byte |

## Verification
The bench checks the first byte after reset against the directed value 0x70. A design that unrolled the steps from bit 7 downward would give 0x0E instead. It inserts idle gaps inside the stream: a history that advanced during a gap, or an output that was not held, would break the reference stream from that point on.

A seed load is issued both alone and together with a byte. A design that processed the byte from the old history, or let the load win and dropped the byte's update, would give the wrong result for that byte or the next one. A second instance in descramble mode is fed the scrambled stream. It is then deliberately loaded with a wrong seed. A descrambler that fed back its own output would never resynchronize, and it would fail on every byte after the first.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic {
        MODE_SCRAMBLE   = 1'b0,
        MODE_DESCRAMBLE = 1'b1
    } scr_mode_e;

endpackage

// File: rtl/scr_byte_unroll.sv
module scr_byte_unroll
    import scr_pkg::*;
#(
    parameter int        DATA_W   = 8,
    parameter int        STATE_W  = 7,
    parameter int        TAP_NEAR = 4,
    parameter scr_mode_e MODE     = MODE_SCRAMBLE
) (
    input  logic [STATE_W-1:0] st_in,
    input  logic [DATA_W-1:0]  din,
    output logic [DATA_W-1:0]  dout,
    output logic [STATE_W-1:0] st_out
);
    localparam int NEAR_IDX = TAP_NEAR - 1;
    localparam int FAR_IDX  = STATE_W - 1;

    logic [STATE_W-1:0] chain [0:DATA_W];
    logic [DATA_W-1:0]  fed_bit;

    assign chain[0] = st_in;

    for (genvar i = 0; i < DATA_W; i++) begin : g_step
        logic fb;
        assign fb      = chain[i][NEAR_IDX] ^ chain[i][FAR_IDX];
        assign dout[i] = din[i] ^ fb;
        if (MODE == MODE_SCRAMBLE) begin : g_scr
            assign fed_bit[i] = dout[i];
        end else begin : g_dsc
            assign fed_bit[i] = din[i];
        end
        assign chain[i+1] = {chain[i][STATE_W-2:0], fed_bit[i]};
    end

    assign st_out = chain[DATA_W];

endmodule

// File: rtl/scr_state_reg.sv
module scr_state_reg #(
    parameter int                 STATE_W = 7,
    parameter logic [STATE_W-1:0] SEED    = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               load,
    input  logic [STATE_W-1:0] seed_value,
    input  logic [STATE_W-1:0] st_nxt,
    output logic [STATE_W-1:0] st_q,
    output logic [STATE_W-1:0] st_eff
);
    // A same-cycle load feeds the unrolled chain directly.
    always_comb begin
        st_eff = load ? seed_value : st_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEED;
        end else if (adv) begin
            st_q <= st_nxt;
        end else if (load) begin
            st_q <= seed_value;
        end
    end

    // R5
    state_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(st_q));

    // R6
    seed_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !adv) |=> (st_q == $past(seed_value)));

endmodule

// File: rtl/byte_scrambler.sv
module byte_scrambler
    import scr_pkg::*;
#(
    parameter int                 DATA_W   = 8,
    parameter int                 STATE_W  = 7,
    parameter int                 TAP_NEAR = 4,
    parameter logic [STATE_W-1:0] SEED     = '1,
    parameter scr_mode_e          MODE     = MODE_SCRAMBLE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               seed_load,
    input  logic [STATE_W-1:0] seed_value,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data
);
    logic [STATE_W-1:0] st_q;
    logic [STATE_W-1:0] st_eff;
    logic [STATE_W-1:0] st_nxt;
    logic [DATA_W-1:0]  byte_nxt;

    scr_state_reg #(
        .STATE_W (STATE_W),
        .SEED    (SEED)
    ) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (in_valid),
        .load       (seed_load),
        .seed_value (seed_value),
        .st_nxt     (st_nxt),
        .st_q       (st_q),
        .st_eff     (st_eff)
    );

    scr_byte_unroll #(
        .DATA_W   (DATA_W),
        .STATE_W  (STATE_W),
        .TAP_NEAR (TAP_NEAR),
        .MODE     (MODE)
    ) u_unroll (
        .st_in  (st_eff),
        .din    (in_data),
        .dout   (byte_nxt),
        .st_out (st_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= byte_nxt;
            end
        end
    end

    function automatic logic [STATE_W-1:0] tail_rev(input logic [DATA_W-1:0] b);
        logic [STATE_W-1:0] r;
        for (int k = 0; k < STATE_W; k++) begin
            r[k] = b[DATA_W-1-k];
        end
        return r;
    endfunction

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    if (MODE == MODE_SCRAMBLE) begin : g_hist_scr
        // R9
        history_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (st_q == tail_rev(out_data)));
    end else begin : g_hist_dsc
        // R9
        history_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (st_q == tail_rev($past(in_data))));
    end

endmodule

// File: tb/byte_scrambler_tb.sv
module byte_scrambler_tb;
    import scr_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_in_valid = 1'b0;
    logic [7:0] s_in_data = '0;
    logic       s_load = 1'b0;
    logic [6:0] s_seed = '0;
    logic       s_out_valid;
    logic [7:0] s_out_data;
    logic       d_load = 1'b0;
    logic [6:0] d_seed = '0;
    logic       d_out_valid;
    logic [7:0] d_out_data;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    byte_scrambler #(.MODE(MODE_SCRAMBLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .in_data(s_in_data),
        .seed_load(s_load), .seed_value(s_seed),
        .out_valid(s_out_valid), .out_data(s_out_data));

    byte_scrambler #(.MODE(MODE_DESCRAMBLE)) u_desc (
        .clk(clk), .rst_n(rst_n), .in_valid(s_out_valid), .in_data(s_out_data),
        .seed_load(d_load), .seed_value(d_seed),
        .out_valid(d_out_valid), .out_data(d_out_data));

    logic [7:0] s_q[$];
    string      s_tag[$];
    logic [8:0] d_q[$];
    string      d_tag[$];
    logic [6:0] m_st = 7'h7F;
    int         d_skip = 0;
    bit         d_resync = 0;
    logic [7:0] s_last = '0;

    function automatic logic [14:0] mdl(input logic [6:0] st, input logic [7:0] d, input bit desc);
        logic [6:0] s;
        logic [7:0] o;
        s = st;
        for (int i = 0; i < 8; i++) begin
            o[i] = d[i] ^ s[3] ^ s[6];
            s = {s[5:0], desc ? d[i] : o[i]};
        end
        return {s, o};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic push_desc(input logic [7:0] d);
        if (d_skip > 0) begin
            d_q.push_back({1'b0, d});
            d_tag.push_back("-");
            d_skip--;
            d_resync = 1;
        end else begin
            d_q.push_back({1'b1, d});
            d_tag.push_back(d_resync ? "R8 resync" : "R7 descramble");
            d_resync = 0;
        end
    endtask

    task automatic drive(input logic [7:0] d, input bit ld, input logic [6:0] sd,
                         input bit use_exp, input logic [7:0] exp, input string tag);
        logic [14:0] r;
        @(posedge clk); #1;
        s_in_valid = 1'b1;
        s_in_data  = d;
        s_load     = ld;
        s_seed     = sd;
        d_load     = 1'b0;
        r = mdl(ld ? sd : m_st, d, 1'b0);
        m_st = r[14:8];
        s_q.push_back(use_exp ? exp : r[7:0]);
        s_tag.push_back(tag);
        push_desc(d);
    endtask

    task automatic send(input logic [7:0] d, input string tag);
        drive(d, 1'b0, 7'h00, 1'b0, 8'h00, tag);
    endtask

    task automatic idle(input int n);
        @(posedge clk); #1;
        s_in_valid = 1'b0;
        s_load     = 1'b0;
        d_load     = 1'b0;
        repeat (n - 1) @(posedge clk);
    endtask

    // Scoreboard monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            s_last = '0;
        end else begin
            if (s_out_valid) begin
                if (s_q.size() == 0) begin
                    chk("R2 unexpected scrambler output", s_out_data, 8'hxx);
                end else begin
                    chk(s_tag.pop_front(), s_out_data, s_q.pop_front());
                end
                s_last = s_out_data;
            end else begin
                chk("R5 output held while idle", s_out_data, s_last);
            end
            if (d_out_valid) begin
                if (d_q.size() == 0) begin
                    chk("R7 unexpected descrambler output", d_out_data, 8'hxx);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = d_q.pop_front();
                    t = d_tag.pop_front();
                    if (e[8]) chk(t, d_out_data, e[7:0]);
                end
            end
        end
    end

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R4 out_valid in reset", {7'h0, s_out_valid}, 8'h00);
        chk("R4 out_data in reset", s_out_data, 8'h00);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R3 bit order with all-ones reset history
        drive(8'h00, 1'b0, 7'h00, 1'b1, 8'h70, "R3 bit0 first");
        send(8'hFF, "R1 ones");
        send(8'hA5, "R1 alt");
        send(8'h5A, "R1 alt2");
        send(8'h00, "R1 zeros");
        send(8'h00, "R1 zeros");
        for (int i = 0; i < 16; i++) send(8'(i * 37 + 11), "R2 back-to-back");
        idle(3);

        // R5 history frozen across gaps
        send(8'h3C, "R5 before gap");
        idle(5);
        send(8'hC3, "R5 after gap");
        idle(1);
        send(8'h11, "R5 single");
        idle(3);

        // R6 seed load alone
        @(posedge clk); #1;
        s_load = 1'b1;
        s_seed = 7'h2A;
        m_st = 7'h2A;
        d_skip = 1;
        @(posedge clk); #1;
        s_load = 1'b0;
        send(8'h81, "R6 after load");
        send(8'h42, "R6 after load");
        // R6 seed load with byte in same cycle
        d_skip = 1;
        drive(8'h96, 1'b1, 7'h55, 1'b0, 8'h00, "R6 load with byte");
        send(8'h69, "R6 following byte");
        // R6 zero seed with zero data stays zero
        d_skip = 1;
        drive(8'h00, 1'b1, 7'h00, 1'b1, 8'h00, "R6 zero seed");
        send(8'h00, "R6 zero history");
        send(8'h01, "R6 leave zero");
        idle(3);

        // R8 descrambler loaded with a wrong history
        @(posedge clk); #1;
        d_load = 1'b1;
        d_seed = 7'h15;
        d_skip = 1;
        @(posedge clk); #1;
        d_load = 1'b0;
        for (int i = 0; i < 8; i++) send(8'(i * 91 + 7), "R1 stream");
        idle(3);

        // R4 reset mid-run restores the seed
        @(posedge clk); #1;
        rst_n = 1'b0;
        m_st = 7'h7F;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R4 out_valid after reset", {7'h0, s_out_valid}, 8'h00);
        chk("R4 out_data after reset", s_out_data, 8'h00);
        @(posedge clk); #1;
        rst_n = 1'b1;
        drive(8'h00, 1'b0, 7'h00, 1'b1, 8'h70, "R4 seed restored");
        send(8'hE7, "R1 after reset");
        idle(4);

        chk("R2 scrambler queue drained", 8'(s_q.size()), 8'h00);
        chk("R7 descrambler queue drained", 8'(d_q.size()), 8'h00);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule